// File: doc/BRIEF.md
# Lockable Watchdog Timer with Sticky Reset-Cause Flag

This block watches over software running on a small controller. Software writes a 5-bit start value that selects the timeout, then sets an arm bit. From then on software has to write the feed register often enough to keep the internal counter from reaching the end of its period. If it fails to, the block raises a system reset request for a fixed number of cycles. It also sets a cause flag, which software reads after the reset to tell a watchdog reset from an ordinary one.

The timeout is 2^(S+1) clock cycles, where S is the start value. An interrupt enable bit adds an early-warning interrupt at half the period. Once the block is armed, no register write can disarm it or change its period. Only the power-on reset clears the arm bit. While the power-down input is high, the counter is held at zero. The power-on reset is the only reset of the block, so the cause flag keeps its value across the reset request that the block itself issues.

Register map (2-bit address, 8-bit data). The read data path is combinational from `rd_addr`.
- Address 0, start value: bits 4:0 hold S; bits 7:5 are dropped on write and read as 0.
- Address 1, control: bit 7 is arm (write 1 to arm; writing 0 has no effect); bit 6 is the interrupt enable.
- Address 2, feed: any write feeds the counter; reads return 0.
- Address 3, status: bit 0 is the cause flag (write 1 to clear); bit 5 is the interrupt pending flag (write 1 to clear); bit 7 mirrors arm.

Top module: `wdt_guard`

## Requirements
- R1: After power-on reset, `wdt_rst_req` and `wdt_irq` are 0, and addresses 0, 1 and 3 read 0.
- R2: A write to address 0 keeps only bits 4:0, so writing 0xFF reads back 0x1F and writing 0x23 reads back 0x03.
- R3: With start value S and no feed, `wdt_rst_req` first goes high 2^(S+1) rising edges after the edge that takes the arm write (control bit 7 = 1).
- R4: A write to address 2 returns the count to zero. Feeding at intervals shorter than the timeout prevents any reset request, and the request then comes 2^(S+1) edges after the last feed edge.
- R5: Once raised, `wdt_rst_req` stays high for exactly 16 cycles, provided no further expiry falls inside that window.
- R6: An expiry sets the cause flag (status bit 0). The flag is still 1 after the reset request ends. Writing 0 to status bit 0 leaves it set; writing 1 clears it.
- R7: After arming, writing 0 to control bit 7 leaves the block armed (control bit 7 still reads 1).
- R8: After arming, writes to address 0 are ignored and the start value keeps reading its old value.
- R9: With the interrupt enable (control bit 6) set, `wdt_irq` and status bit 5 go high 2^S edges after the arm edge. Writing 1 to status bit 5 clears both.
- R10: With the interrupt enable clear, `wdt_irq` and status bit 5 stay 0 through expiries.
- R11: While `pwr_down` is high, no reset request is made. After `pwr_down` falls, a full 2^(S+1)-edge period passes before the request.
- R12: Power-on reset clears the arm bit and the cause flag, even after an expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| pwr_down | input | 1 | Power-down indication; holds the counter at zero |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| wdt_rst_req | output | 1 | System reset request, 16 cycles per expiry |
| wdt_irq | output | 1 | Early-warning interrupt, level |

## Verification
The bench measures the expiry edge for several start values, including raw bytes with stray upper bits. A design that mis-masked the start value, or that counted one edge early or late from the arm edge, would report a timeout off by a power of two or by one cycle. It then attempts to disarm the block and to rewrite its period after arming; a design that accepted either would read back a cleared arm bit or a new start value. It also checks the length of the reset pulse, that the cause flag stays set after the pulse, that a zero write leaves the flag set, and that power-down holds the counter and restarts the full period on release. These catch a stretcher of the wrong length and a flag that clears on the wrong write. They also catch a counter that resumes from its old value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WDT_SV_W  = 5;
  localparam int WDT_CNT_W = (1 << WDT_SV_W) + 1;
  localparam int WDT_DW    = 8;
  localparam int WDT_AW    = 2;

  typedef enum logic [WDT_AW-1:0] {
    RA_START  = 2'd0,
    RA_CTRL   = 2'd1,
    RA_FEED   = 2'd2,
    RA_STATUS = 2'd3
  } wdt_addr_e;

  localparam int BIT_ARM    = 7;
  localparam int BIT_IRQEN  = 6;
  localparam int BIT_PEND   = 5;
  localparam int BIT_CAUSE  = 0;

  // Final count before expiry: 2^(sv+1) - 1
  function automatic logic [WDT_CNT_W-1:0] last_count(input logic [WDT_SV_W-1:0] sv);
    logic [WDT_CNT_W-1:0] one;
    one = WDT_CNT_W'(1);
    return (one << ({1'b0, sv} + 6'd1)) - one;
  endfunction

  // Count at which the half-period warning fires: 2^sv - 1
  function automatic logic [WDT_CNT_W-1:0] half_count(input logic [WDT_SV_W-1:0] sv);
    logic [WDT_CNT_W-1:0] one;
    one = WDT_CNT_W'(1);
    return (one << sv) - one;
  endfunction
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 run,
  input  logic                 feed,
  input  logic [WDT_SV_W-1:0]  start_val,
  output logic                 expire,
  output logic                 halfway,
  output logic [WDT_CNT_W-1:0] cnt
);
  logic at_end;
  logic at_half;

  assign at_end  = (cnt == last_count(start_val));
  assign at_half = (cnt == half_count(start_val));
  assign expire  = run && !feed && at_end;
  assign halfway = run && !feed && at_half;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               cnt <= '0;
    else if (!run)            cnt <= '0;
    else if (feed || expire)  cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!por_n)
    run |-> (cnt <= last_count(start_val)));

  assert_pd_hold_R11: assert property (@(posedge clk) disable iff (!por_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic expire,
  output logic rst_req
);
  localparam int PC_W = $clog2(PULSE_LEN + 1);

  logic [PC_W-1:0] left;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           left <= '0;
    else if (expire)      left <= PC_W'(PULSE_LEN);
    else if (left != '0)  left <= left - 1'b1;
  end

  assign rst_req = (left != '0);

  assert_rst_cause_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_req) |-> $past(expire));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic                clk,
  input  logic                por_n,
  input  logic                wr_en,
  input  logic [WDT_AW-1:0]   wr_addr,
  input  logic [WDT_DW-1:0]   wr_data,
  input  logic [WDT_AW-1:0]   rd_addr,
  input  logic                expire,
  input  logic                halfway,
  output logic [WDT_DW-1:0]   rd_data,
  output logic [WDT_SV_W-1:0] start_val,
  output logic                armed,
  output logic                irq_en,
  output logic                cause,
  output logic                pending,
  output logic                feed
);
  logic wr_start, wr_ctrl, wr_stat;

  assign wr_start = wr_en && (wr_addr == RA_START);
  assign wr_ctrl  = wr_en && (wr_addr == RA_CTRL);
  assign wr_stat  = wr_en && (wr_addr == RA_STATUS);
  assign feed     = wr_en && (wr_addr == RA_FEED);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      start_val <= '0;
      armed     <= 1'b0;
      irq_en    <= 1'b0;
    end else begin
      if (wr_start && !armed)            start_val <= wr_data[WDT_SV_W-1:0];
      if (wr_ctrl && wr_data[BIT_ARM])   armed     <= 1'b1;
      if (wr_ctrl)                       irq_en    <= wr_data[BIT_IRQEN];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause   <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (expire)                             cause <= 1'b1;
      else if (wr_stat && wr_data[BIT_CAUSE]) cause <= 1'b0;
      if (halfway && irq_en)                  pending <= 1'b1;
      else if (wr_stat && wr_data[BIT_PEND])  pending <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      RA_START:  rd_data[WDT_SV_W-1:0] = start_val;
      RA_CTRL: begin
        rd_data[BIT_ARM]   = armed;
        rd_data[BIT_IRQEN] = irq_en;
      end
      RA_FEED:   rd_data = '0;
      RA_STATUS: begin
        rd_data[BIT_ARM]   = armed;
        rd_data[BIT_PEND]  = pending;
        rd_data[BIT_CAUSE] = cause;
      end
      default:   rd_data = '0;
    endcase
  end

  assert_armed_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
    armed |=> armed);

  assert_start_frozen_R8: assert property (@(posedge clk) disable iff (!por_n)
    armed |=> $stable(start_val));

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!por_n)
    expire |=> cause);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pwr_down,
  input  logic              wr_en,
  input  logic [WDT_AW-1:0] wr_addr,
  input  logic [WDT_DW-1:0] wr_data,
  input  logic [WDT_AW-1:0] rd_addr,
  output logic [WDT_DW-1:0] rd_data,
  output logic              wdt_rst_req,
  output logic              wdt_irq
);
  logic [WDT_SV_W-1:0]  start_val;
  logic [WDT_CNT_W-1:0] cnt;
  logic armed, irq_en, cause, pending, feed;
  logic run, expire, halfway;

  assign run     = armed && !pwr_down;
  assign wdt_irq = pending && irq_en;

  wdt_regs u_regs (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .expire(expire),
    .halfway(halfway), .rd_data(rd_data), .start_val(start_val),
    .armed(armed), .irq_en(irq_en), .cause(cause), .pending(pending),
    .feed(feed)
  );

  wdt_counter u_cnt (
    .clk(clk), .por_n(por_n), .run(run), .feed(feed),
    .start_val(start_val), .expire(expire), .halfway(halfway), .cnt(cnt)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .por_n(por_n), .expire(expire), .rst_req(wdt_rst_req)
  );

  assert_pd_quiet_R11: assert property (@(posedge clk) disable iff (!por_n)
    pwr_down |-> !expire);
endmodule

// File: tb/wdt_guard_bench.sv
`timescale 1ns/100ps
module wdt_guard_bench;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic pwr_down = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic wdt_rst_req, wdt_irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wdt_guard u_wdt_guard (
    .clk(clk), .por_n(por_n), .pwr_down(pwr_down), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
  );

  localparam int NV = 5;
  localparam logic [7:0] VEC_RAW [NV] = '{8'h00, 8'h23, 8'h04, 8'hE5, 8'h27};
  localparam logic [7:0] VEC_SV  [NV] = '{8'h00, 8'h03, 8'h04, 8'h05, 8'h07};
  localparam int         VEC_T   [NV] = '{2, 16, 32, 64, 256};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic por_pulse();
    @(negedge clk);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
  endtask

  task automatic edges_to_rst(output int k);
    k = 0;
    while (!wdt_rst_req && k < 1000) begin
      @(posedge clk); k++; @(negedge clk);
    end
  endtask

  task automatic edges_to_irq(output int k);
    k = 0;
    while (!wdt_irq && k < 1000) begin
      @(posedge clk); k++; @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int k;
    bit seen;

    // R1 reset state
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk(!wdt_rst_req && !wdt_irq, "R1 outputs", {wdt_rst_req, wdt_irq}, 0);
    rd(2'd0, d); chk(d == 8'h00, "R1 start reg", d, 0);
    rd(2'd1, d); chk(d == 8'h00, "R1 ctrl reg", d, 0);
    rd(2'd3, d); chk(d == 8'h00, "R1 status reg", d, 0);

    // Vector table: R2 masking and R3 timeout
    for (int i = 0; i < NV; i++) begin
      por_pulse();
      wr(2'd0, VEC_RAW[i]);
      rd(2'd0, d);
      chk(d == VEC_SV[i], "R2 start mask", d, VEC_SV[i]);
      wr(2'd1, 8'h80);
      edges_to_rst(k);
      chk(k == VEC_T[i], "R3 timeout edges", k, VEC_T[i]);
    end
    rd(2'd3, d);
    chk(d[0] == 1'b1, "R6 cause set", d[0], 1);

    // R4 feeding
    por_pulse();
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h80);
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 10; j++) begin
        @(negedge clk);
        if (wdt_rst_req) seen = 1'b1;
      end
      wr(2'd2, 8'h00);
      if (wdt_rst_req) seen = 1'b1;
    end
    chk(!seen, "R4 fed no reset", seen, 0);
    edges_to_rst(k);
    chk(k == 16, "R4 after last feed", k, 16);

    // R9 interrupt, R5 pulse width, R6 flag behaviour
    por_pulse();
    wr(2'd0, 8'h04);
    wr(2'd1, 8'hC0);
    edges_to_irq(k);
    chk(k == 16, "R9 irq edges", k, 16);
    rd(2'd3, d);
    chk(d[5] == 1'b1, "R9 pending bit", d[5], 1);
    wr(2'd3, 8'h20);
    rd(2'd3, d);
    chk(d[5] == 1'b0 && !wdt_irq, "R9 pending cleared", {d[5], wdt_irq}, 0);
    chk(d[0] == 1'b0, "R6 cause before expiry", d[0], 0);
    edges_to_rst(k);
    k = 0;
    while (wdt_rst_req && k < 100) begin
      k++; @(negedge clk);
    end
    chk(k == 16, "R5 pulse width", k, 16);
    rd(2'd3, d);
    chk(d[0] == 1'b1, "R6 cause survives pulse", d[0], 1);
    wr(2'd3, 8'h00);
    rd(2'd3, d);
    chk(d[0] == 1'b1, "R6 zero write keeps cause", d[0], 1);
    wr(2'd3, 8'h01);
    rd(2'd3, d);
    chk(d[0] == 1'b0, "R6 one write clears cause", d[0], 0);

    // R12 power-on reset after expiry
    por_pulse();
    @(negedge clk);
    rd(2'd1, d); chk(d == 8'h00, "R12 arm cleared", d, 0);
    rd(2'd3, d); chk(d == 8'h00, "R12 status cleared", d, 0);

    // R10 interrupt disabled
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h80);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (wdt_irq) seen = 1'b1;
    end
    rd(2'd3, d);
    chk(!seen && d[5] == 1'b0, "R10 no irq", {seen, d[5]}, 0);

    // R7 and R8 lock after arming
    por_pulse();
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h80);
    wr(2'd1, 8'h00);
    rd(2'd1, d);
    chk(d[7] == 1'b1, "R7 still armed", d[7], 1);
    wr(2'd0, 8'h1F);
    rd(2'd0, d);
    chk(d == 8'h02, "R8 start frozen", d, 2);

    // R11 power-down
    por_pulse();
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h80);
    repeat (5) @(negedge clk);
    pwr_down = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (wdt_rst_req) seen = 1'b1;
    end
    chk(!seen, "R11 no reset in power-down", seen, 0);
    pwr_down = 1'b0;
    edges_to_rst(k);
    chk(k == 16, "R11 full period after release", k, 16);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule